// File: doc/BRIEF.md
# Scan-Port Memory Access Bridge

This block lets a debug host read and write a byte-wide system bus through a boundary-scan test port. It sits behind an existing test-access controller. From that controller it takes the current instruction code and the capture, shift and update state decodes, together with the test clock and serial input. It returns the serial output.

Three instructions are decoded here:

- **Address select** exposes a 16-bit address register.
- **Read** exposes an 8-bit data register whose scans only fetch.
- **Read-modify** exposes an 8-bit data register whose scans return the old byte at the current address and then store the byte shifted in.

Every data scan moves the address on by one. A host can therefore stream a block of memory with repeated 8-bit scans after loading a start address once.

On the bus side the block is a single master on a classic-cycle bus with a 16-bit address and 8-bit data. That bus runs on its own system clock. Requests cross from the test-clock domain by toggling a flag that the system side sees through a two-flop synchronizer. Completions come back the same way.

A read is started when the data register is captured. The fetched byte must arrive before the first shift edge. This requires the system clock to run well ahead of the test clock; a ratio of ten is the intended setting. If the target never acknowledges, the cycle is dropped after a bounded count and the data register presents all ones.

Top module: `dbg_bus_bridge`

## Requirements
- R1: After both resets the address register holds 0x0000 and the bus cycle signal `wb_cyc` is low.
- R2: With instruction code 3'b100 the scan register is 16 bits, shifted least significant bit first. Capture loads it with the current address, so a scan returns the old address. Update loads the shifted-in value as the new address.
- R3: Each update in instruction 3'b101 or 3'b110 increments the address by one. Two data scans from 0xC000 leave 0xC002.
- R4: With instruction code 3'b110 an 8-bit scan, least significant bit first, returns the byte stored at the current address. At update it writes the shifted-in byte to that same address.
- R5: With instruction code 3'b101 a scan returns the byte at the current address. The shifted-in bits are ignored and no write cycle is issued.
- R6: `wb_cyc` and `wb_stb` rise together and stay high, with address, write data and `wb_we` unchanged, until `wb_ack`. `wb_we` is high only during write cycles.
- R7: If no acknowledge arrives within `TMO_CYC` system clocks, the cycle ends anyway. A read abandoned this way returns 0xFF, and an abandoned write stores nothing.
- R8: Any other instruction code issues no bus cycle, leaves the address unchanged and drives `tdo` low.
- R9: Each data capture issues exactly one bus cycle. Each read-modify update issues exactly one more. No completion returns without a request outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst_n | input | 1 | Asynchronous active-low reset, test-clock domain |
| ir_code | input | 3 | Current instruction from the access controller |
| capture_dr | input | 1 | Controller is in the data-capture state |
| shift_dr | input | 1 | Controller is in the data-shift state |
| update_dr | input | 1 | Controller is in the data-update state |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| sys_clk | input | 1 | System bus clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset, system domain |
| wb_cyc | output | 1 | Bus cycle in progress |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Write enable |
| wb_adr | output | 16 | Bus address |
| wb_dat_w | output | 8 | Write data |
| wb_dat_r | input | 8 | Read data |
| wb_ack | input | 1 | Cycle acknowledge from target |

## Verification
The assertions take four things for granted about the inputs:

- The state decodes are mutually exclusive and change only while `tck` is low.
- `ir_code` holds steady through a whole scan.
- At least two idle test clocks separate an update from the next capture, so a write finishes and its completion returns before the next request.
- The system clock runs at least eight times faster than the test clock, so a fetched byte is in place before the first shift sample.

The bench drives the test clock by hand at one tenth of the 125 MHz system clock. It changes every decode just after a falling edge and leaves three idle clocks after each update. In timeout scans it holds the controller idle for three extra clocks after capture, so the abandoned read has settled before shifting starts.

// File: rtl/dbgb_pkg.sv
package dbgb_pkg;
  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] IR_ADDR = 3'b100;
  localparam logic [IR_W-1:0] IR_READ = 3'b101;
  localparam logic [IR_W-1:0] IR_RDWR = 3'b110;
endpackage

// File: rtl/dbgb_sync.sv
module dbgb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/dbgb_scan.sv
module dbgb_scan import dbgb_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic            tck,
  input  logic            tck_rst_n,
  input  logic [IR_W-1:0] ir_code,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  output logic            tdo,
  input  logic [DW-1:0]   rd_hold,
  output logic            req_tgl,
  output logic            req_wr,
  output logic [AW-1:0]   req_adr,
  output logic [DW-1:0]   req_dat,
  input  logic            done_tgl
);
  logic [AW-1:0] addr_q, asr_q;
  logic [DW-1:0] dsr_q, cur;
  logic          fresh_q, done_s, busy;
  logic          sel_adr, sel_rd, sel_rw, sel_dat;

  dbgb_sync #(.STAGES(2)) u_done_sync (
    .clk(tck), .rst_n(tck_rst_n), .d(done_tgl), .q(done_s)
  );

  assign sel_adr = (ir_code == IR_ADDR);
  assign sel_rd  = (ir_code == IR_READ);
  assign sel_rw  = (ir_code == IR_RDWR);
  assign sel_dat = sel_rd | sel_rw;
  // first bit after capture comes straight from the fetched byte
  assign cur     = fresh_q ? rd_hold : dsr_q;
  assign busy    = req_tgl ^ done_s;
  assign tdo     = sel_adr ? asr_q[0] : (sel_dat ? cur[0] : 1'b0);

  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n) begin
      addr_q  <= '0;
      asr_q   <= '0;
      dsr_q   <= '0;
      fresh_q <= 1'b0;
      req_tgl <= 1'b0;
      req_wr  <= 1'b0;
      req_adr <= '0;
      req_dat <= '0;
    end else if (sel_adr) begin
      if (capture_dr)     asr_q  <= addr_q;
      else if (shift_dr)  asr_q  <= {tdi, asr_q[AW-1:1]};
      else if (update_dr) addr_q <= asr_q;
    end else if (sel_dat) begin
      if (capture_dr) begin
        fresh_q <= 1'b1;
        req_tgl <= ~req_tgl;
        req_wr  <= 1'b0;
        req_adr <= addr_q;
      end else if (shift_dr) begin
        dsr_q   <= {tdi, cur[DW-1:1]};
        fresh_q <= 1'b0;
      end else if (update_dr) begin
        fresh_q <= 1'b0;
        addr_q  <= addr_q + 1'b1;
        if (sel_rw) begin
          req_tgl <= ~req_tgl;
          req_wr  <= 1'b1;
          req_adr <= addr_q;
          req_dat <= dsr_q;
        end
      end
    end
  end

  // R9
  done_needs_req_chk: assert property (@(posedge tck) disable iff (!tck_rst_n)
    (done_s != $past(done_s)) |-> $past(busy));

  // R8
  other_ir_quiet_chk: assert property (@(posedge tck) disable iff (!tck_rst_n)
    !(sel_adr || sel_dat) |=> ($stable(req_tgl) && $stable(addr_q)));
endmodule

// File: rtl/dbgb_bus.sv
module dbgb_bus #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int TMO_CYC = 8
) (
  input  logic          sys_clk,
  input  logic          sys_rst_n,
  input  logic          req_tgl,
  input  logic          req_wr,
  input  logic [AW-1:0] req_adr,
  input  logic [DW-1:0] req_dat,
  output logic [DW-1:0] rd_hold,
  output logic          done_tgl,
  output logic          wb_cyc,
  output logic          wb_stb,
  output logic          wb_we,
  output logic [AW-1:0] wb_adr,
  output logic [DW-1:0] wb_dat_w,
  input  logic [DW-1:0] wb_dat_r,
  input  logic          wb_ack
);
  localparam int CW = $clog2(TMO_CYC + 1);

  logic          req_s, req_d, req_edge;
  logic          cyc_q, we_q;
  logic [CW-1:0] cnt_q;

  dbgb_sync #(.STAGES(2)) u_req_sync (
    .clk(sys_clk), .rst_n(sys_rst_n), .d(req_tgl), .q(req_s)
  );

  assign req_edge = req_s ^ req_d;
  assign wb_cyc   = cyc_q;
  assign wb_stb   = cyc_q;
  assign wb_we    = we_q;

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      req_d    <= 1'b0;
      cyc_q    <= 1'b0;
      we_q     <= 1'b0;
      cnt_q    <= '0;
      wb_adr   <= '0;
      wb_dat_w <= '0;
      rd_hold  <= '0;
      done_tgl <= 1'b0;
    end else if (!cyc_q) begin
      // a request is consumed only while idle, so none is lost
      if (req_edge) begin
        req_d    <= req_s;
        cyc_q    <= 1'b1;
        we_q     <= req_wr;
        wb_adr   <= req_adr;
        wb_dat_w <= req_dat;
        cnt_q    <= '0;
      end
    end else if (wb_ack) begin
      cyc_q    <= 1'b0;
      we_q     <= 1'b0;
      done_tgl <= ~done_tgl;
      if (!we_q) rd_hold <= wb_dat_r;
    end else if (cnt_q == CW'(TMO_CYC - 1)) begin
      cyc_q    <= 1'b0;
      we_q     <= 1'b0;
      done_tgl <= ~done_tgl;
      if (!we_q) rd_hold <= '1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R6
  cycle_hold_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wb_cyc && !wb_ack && (cnt_q != CW'(TMO_CYC - 1))) |=>
      (wb_cyc && $stable(wb_adr) && $stable(wb_we) && $stable(wb_dat_w)));

  // R6
  we_inside_cyc_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    wb_we |-> (wb_cyc && wb_stb));

  // R7
  tmo_bound_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    wb_cyc |-> (cnt_q < CW'(TMO_CYC)));

  // R9
  cycle_from_req_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    $rose(wb_cyc) |-> $past(req_edge));
endmodule

// File: rtl/dbg_bus_bridge.sv
module dbg_bus_bridge import dbgb_pkg::*; #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int TMO_CYC = 8
) (
  input  logic            tck,
  input  logic            tck_rst_n,
  input  logic [IR_W-1:0] ir_code,
  input  logic            capture_dr,
  input  logic            shift_dr,
  input  logic            update_dr,
  input  logic            tdi,
  output logic            tdo,
  input  logic            sys_clk,
  input  logic            sys_rst_n,
  output logic            wb_cyc,
  output logic            wb_stb,
  output logic            wb_we,
  output logic [AW-1:0]   wb_adr,
  output logic [DW-1:0]   wb_dat_w,
  input  logic [DW-1:0]   wb_dat_r,
  input  logic            wb_ack
);
  logic          req_tgl, req_wr, done_tgl;
  logic [AW-1:0] req_adr;
  logic [DW-1:0] req_dat, rd_hold;

  dbgb_scan #(.AW(AW), .DW(DW)) u_scan (
    .tck(tck), .tck_rst_n(tck_rst_n), .ir_code(ir_code),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .rd_hold(rd_hold),
    .req_tgl(req_tgl), .req_wr(req_wr), .req_adr(req_adr), .req_dat(req_dat),
    .done_tgl(done_tgl)
  );

  dbgb_bus #(.AW(AW), .DW(DW), .TMO_CYC(TMO_CYC)) u_bus (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .req_tgl(req_tgl), .req_wr(req_wr), .req_adr(req_adr), .req_dat(req_dat),
    .rd_hold(rd_hold), .done_tgl(done_tgl),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack)
  );
endmodule

// File: tb/dbg_bus_bridge_bench.sv
`timescale 1ns/1ps
module dbg_bus_bridge_bench;
  logic        tck = 1'b0, sys_clk = 1'b0;
  logic        tck_rst_n = 1'b0, sys_rst_n = 1'b0;
  logic [2:0]  ir_code = 3'b000;
  logic        capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic        tdo, wb_cyc, wb_stb, wb_we;
  logic [15:0] wb_adr;
  logic [7:0]  wb_dat_w;
  logic [7:0]  wb_dat_r = 8'h00;
  logic        wb_ack = 1'b0;

  int checks = 0, failures = 0;
  int cyc_rises = 0, writes_done = 0;
  logic mute = 1'b0, cyc_prev = 1'b0, ended = 1'b0;
  logic [7:0] mem [256];

  dbg_bus_bridge u_dbg_bus_bridge (
    .tck(tck), .tck_rst_n(tck_rst_n), .ir_code(ir_code),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .tdo(tdo), .sys_clk(sys_clk), .sys_rst_n(sys_rst_n),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack)
  );

  always #4 sys_clk = ~sys_clk;

  // bench target: one-cycle acknowledge, silent while muted
  always @(posedge sys_clk) begin
    cyc_prev <= wb_cyc;
    if (wb_cyc && !cyc_prev) cyc_rises <= cyc_rises + 1;
    if (wb_cyc && wb_stb && !wb_ack && !mute) begin
      wb_ack <= 1'b1;
      wb_dat_r <= mem[wb_adr[7:0]];
      if (wb_we) begin
        mem[wb_adr[7:0]] <= wb_dat_w;
        writes_done <= writes_done + 1;
      end
    end else begin
      wb_ack <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(output logic smp);
    #20 smp = tdo;
    #20 tck = 1'b1;
    #40 tck = 1'b0;
  endtask

  task automatic scan(input logic [2:0] ir, input int n, input logic [15:0] din,
                      input int gap, output logic [15:0] dout);
    logic s;
    dout = '0;
    ir_code = ir;
    capture_dr = 1'b1; tick(s); capture_dr = 1'b0;
    for (int g = 0; g < gap; g++) tick(s);
    for (int i = 0; i < n; i++) begin
      shift_dr = 1'b1; tdi = din[i];
      tick(s); dout[i] = s;
    end
    shift_dr = 1'b0; update_dr = 1'b1; tick(s); update_dr = 1'b0;
    for (int g = 0; g < 3; g++) tick(s);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R1 cyc low after reset", {15'd0, wb_cyc}, 16'h0000);
    scan(3'b100, 16, 16'hC000, 0, d);
    check("R1 address after reset", d, 16'h0000);
  endtask

  task automatic t_addr();
    logic [15:0] d;
    scan(3'b100, 16, 16'hBEEF, 0, d);
    check("R2 old address out", d, 16'hC000);
    scan(3'b100, 16, 16'hC000, 0, d);
    check("R2 loaded address out", d, 16'hBEEF);
  endtask

  task automatic t_rw_fill();
    logic [15:0] d;
    int c0, w0;
    c0 = cyc_rises; w0 = writes_done;
    scan(3'b110, 8, 16'h0055, 0, d);
    check("R4 first old byte", d, 16'h0000);
    scan(3'b110, 8, 16'h00AA, 0, d);
    check("R4 second old byte", d, 16'h0000);
    check("R9 four cycles for two read-modify scans", 16'(cyc_rises - c0), 16'd4);
    check("R6 two write cycles", 16'(writes_done - w0), 16'd2);
    scan(3'b100, 16, 16'hC000, 0, d);
    check("R3 address advanced by two", d, 16'hC002);
  endtask

  task automatic t_rw_swap();
    logic [15:0] d;
    scan(3'b110, 8, 16'h00AA, 0, d);
    check("R4 returns 55", d, 16'h0055);
    scan(3'b110, 8, 16'h0055, 0, d);
    check("R4 returns AA", d, 16'h00AA);
    scan(3'b100, 16, 16'hC000, 0, d);
    check("R3 address after swap", d, 16'hC002);
  endtask

  task automatic t_read();
    logic [15:0] d;
    int c0, w0;
    c0 = cyc_rises; w0 = writes_done;
    scan(3'b101, 8, 16'h00FF, 0, d);
    check("R5 read first byte", d, 16'h00AA);
    scan(3'b101, 8, 16'h0000, 0, d);
    check("R5 read second byte", d, 16'h0055);
    check("R5 no writes in read mode", 16'(writes_done - w0), 16'd0);
    check("R9 one cycle per read scan", 16'(cyc_rises - c0), 16'd2);
    scan(3'b100, 16, 16'hC000, 0, d);
    check("R3 address after reads", d, 16'hC002);
    scan(3'b101, 8, 16'h0011, 0, d);
    check("R5 ignored bits left memory intact", d, 16'h00AA);
  endtask

  task automatic t_timeout();
    logic [15:0] d;
    int w0;
    scan(3'b100, 16, 16'h1234, 0, d);
    mute = 1'b1;
    w0 = writes_done;
    scan(3'b101, 8, 16'h0000, 3, d);
    check("R7 abandoned read gives FF", d, 16'h00FF);
    check("R7 cycle dropped", {15'd0, wb_cyc}, 16'h0000);
    scan(3'b110, 8, 16'h003C, 3, d);
    check("R7 read-modify read gives FF", d, 16'h00FF);
    mute = 1'b0;
    check("R7 no write accepted", 16'(writes_done - w0), 16'd0);
    scan(3'b100, 16, 16'h1235, 0, d);
    check("R3 address advanced past timeouts", d, 16'h1236);
    scan(3'b101, 8, 16'h0000, 0, d);
    check("R7 abandoned write stored nothing", d, 16'h0000);
  endtask

  task automatic t_other();
    logic [15:0] d;
    int c0;
    scan(3'b100, 16, 16'h00F0, 0, d);
    c0 = cyc_rises;
    scan(3'b011, 8, 16'h00A5, 0, d);
    check("R8 tdo low", d, 16'h0000);
    check("R8 no bus cycle", 16'(cyc_rises - c0), 16'd0);
    scan(3'b100, 16, 16'h0000, 0, d);
    check("R8 address unchanged", d, 16'h00F0);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    #100;
    tck_rst_n = 1'b1;
    sys_rst_n = 1'b1;
    #100;
    t_reset();
    t_addr();
    t_rw_fill();
    scan(3'b100, 16, 16'hC000, 0, tmp_d);
    t_rw_swap();
    scan(3'b100, 16, 16'hC000, 0, tmp_d);
    t_read();
    t_timeout();
    t_other();
    finish_run();
  end

  logic [15:0] tmp_d;

  initial begin
    #1000000;
    checks++;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end
endmodule